// File: doc/BRIEF.md
# Active Priority Stack Tracker

This block records, for a single processor interface of an interrupt controller, which preemption levels are active at the moment. It holds two banked bitmaps of active levels, one for group 0 and one for group 1, and from them it derives the running priority that gates further preemption. Interrupt selection and bus decoding take place outside the block. The block reacts to three events: a binary-point write, an acknowledge, and a priority drop.

An acknowledge carries the 8-bit priority of the interrupt and its group bit. The current binary point masks that priority down to its group priority. The group priority, shifted down to a preemption level, sets one bit in the bank of the interrupt's group. The running priority then takes the group priority directly. A priority drop carries a group bit and the completed interrupt ID. It clears only the lowest set bit of that group's bank. The running priority is then rebuilt from the lowest set bit across both banks, or returns to the idle value 0x100 when nothing is active. Software is expected to nest acknowledges and drops, so the bit a drop clears is the most urgent active level.

Top module: `active_prio_tracker`

## Requirements
- R1: The group priority is the 8-bit acknowledge priority ANDed with all-ones shifted left by (binary point + 1). A binary point of 0 keeps bits [7:1]. A binary point of 7 gives a group priority of 0.
- R2: An acknowledge sets bit (group priority >> (MIN_BP + 1)) in `act_g1` when `ack_grp` is 1, and in `act_g0` when `ack_grp` is 0. Bit index i of each vector stands for level i. The new bit is visible on the first clock edge after the acknowledge.
- R3: On the clock edge after an acknowledge, `run_prio` equals the group priority of the acknowledged interrupt, with bit 8 clear.
- R4: A valid drop clears only the lowest set bit of the bank selected by `drop_grp` (0 selects `act_g0`, 1 selects `act_g1`). The other bank is not changed.
- R5: After a valid drop, `run_prio` equals (index of the lowest set bit of `act_g0 | act_g1`) << (MIN_BP + 1), computed on the banks after the clear. If both banks are empty, `run_prio` becomes 0x100.
- R6: A drop that arrives while `run_prio` is 0x100 changes neither bank nor `run_prio`.
- R7: A drop whose `drop_id` is greater than or equal to NUM_IRQ changes neither bank nor `run_prio`. This includes the spurious ID 1023.
- R8: A binary-point write keeps `bp_wdata[2:0]`, and any value below MIN_BP is raised to MIN_BP. The value held is shown on `bp_q`.
- R9: When an acknowledge and a drop arrive in the same cycle, the drop is applied first and the acknowledge second. Whether the drop is valid is judged on the state before that cycle.
- R10: While reset is held and after it is released, `run_prio` is 0x100, both banks are empty and `bp_q` equals MIN_BP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp_we | input | 1 | Binary-point write strobe |
| bp_wdata | input | 8 | Binary-point write data; only bits [2:0] are used |
| bp_q | output | 3 | Binary point currently held |
| ack_valid | input | 1 | Acknowledge event |
| ack_prio | input | 8 | Priority of the acknowledged interrupt |
| ack_grp | input | 1 | Group of the acknowledged interrupt (1 = group 1) |
| drop_valid | input | 1 | Priority-drop event |
| drop_grp | input | 1 | Group whose bank is popped (1 = group 1) |
| drop_id | input | 10 | ID of the completed interrupt |
| run_prio | output | 9 | Running priority; 0x100 when idle |
| act_g0 | output | LEVELS | Active-level bitmap of group 0 |
| act_g1 | output | LEVELS | Active-level bitmap of group 1 |

## Verification
The bench builds two copies of the block from the same stimulus. The first uses the defaults: MIN_BP 0, 128 levels in four 32-bit words, and NUM_IRQ 96. With it, acknowledges land in different words, and each drop's lowest-bit search has to cross word boundaries within a bank and between the two banks. The second copy uses MIN_BP 2 and NUM_IRQ 64. This makes the clamp on binary-point writes visible, moves the level shift to three bits, and places the invalid-ID limit at 64 instead of 96.

// File: rtl/apt_pkg.sv
package apt_pkg;
  // Width of an interrupt priority and of the running priority.
  localparam int PRIO_W = 8;
  localparam int RUN_W  = PRIO_W + 1;
  // Running priority reported when no level is active.
  localparam logic [RUN_W-1:0] RUN_IDLE = 9'h100;
  // Width of the binary point.
  localparam int BP_W   = 3;
endpackage

// File: rtl/apt_bpr.sv
// Binary-point register: low three bits kept, floored at MIN_BP.
module apt_bpr
  import apt_pkg::*;
#(
  parameter int MIN_BP = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [7:0]      wdata,
  output logic [BP_W-1:0] bp_q
);
  localparam logic [BP_W-1:0] FLOOR = BP_W'(MIN_BP);

  logic [BP_W-1:0] bp_nx;
  logic            unused_hi;

  assign unused_hi = ^wdata[7:BP_W];

  always_comb begin
    bp_nx = wdata[BP_W-1:0];
    if (bp_nx < FLOOR) bp_nx = FLOOR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bp_q <= FLOOR;
    else if (we) bp_q <= bp_nx;
  end
endmodule

// File: rtl/apt_gprio.sv
// Group priority and preemption level of an acknowledged interrupt.
module apt_gprio
  import apt_pkg::*;
#(
  parameter int MIN_BP = 0,
  localparam int LVL_W = PRIO_W - MIN_BP - 1
) (
  input  logic [BP_W-1:0]   bp,
  input  logic [PRIO_W-1:0] prio,
  output logic [PRIO_W-1:0] gprio,
  output logic [LVL_W-1:0]  level
);
  logic [PRIO_W:0] mask_w;

  // A shift of up to 8 on a 9-bit field lets a binary point of 7 mask everything.
  assign mask_w = {(PRIO_W+1){1'b1}} << ({1'b0, bp} + 4'd1);
  assign gprio  = prio & mask_w[PRIO_W-1:0];
  assign level  = gprio[PRIO_W-1:MIN_BP+1];
endmodule

// File: rtl/apt_bank.sv
// One banked active-level bitmap held as words; pop lowest, then push.
module apt_bank #(
  parameter int LEVELS = 128,
  parameter int WORD_W = 32,
  localparam int WORDS = LEVELS / WORD_W,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [LVL_W-1:0]  set_lvl,
  input  logic              clr_en,
  output logic [LEVELS-1:0] bits_q,
  output logic [LEVELS-1:0] bits_nx
);
  logic [WORDS:0]      seen;
  logic [LEVELS-1:0]   cleared;
  logic [LEVELS-1:0]   set_vec;
  logic                upd;

  assign seen[0] = 1'b0;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              nz;
    logic              pop_here;

    assign word_q     = bits_q[w*WORD_W +: WORD_W];
    assign nz         = |word_q;
    assign seen[w+1]  = seen[w] | nz;
    // Only the first non-empty word loses its lowest set bit.
    assign pop_here   = clr_en & nz & ~seen[w];
    assign cleared[w*WORD_W +: WORD_W] =
      pop_here ? (word_q & (word_q - WORD_W'(1))) : word_q;
  end

  assign set_vec = set_en ? (LEVELS'(1) << set_lvl) : '0;
  assign bits_nx = cleared | set_vec;
  assign upd     = set_en | clr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   bits_q <= '0;
    else if (upd) bits_q <= bits_nx;
  end
endmodule

// File: rtl/apt_lowest.sv
// Index of the lowest set bit of a vector.
module apt_lowest #(
  parameter int N = 128,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/active_prio_tracker.sv
module active_prio_tracker
  import apt_pkg::*;
#(
  parameter int MIN_BP  = 0,
  parameter int NUM_IRQ = 96,
  parameter int ID_W    = 10,
  parameter int WORD_W  = 32,
  localparam int LVL_W  = PRIO_W - MIN_BP - 1,
  localparam int LEVELS = 1 << LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bp_we,
  input  logic [7:0]        bp_wdata,
  output logic [BP_W-1:0]   bp_q,
  input  logic              ack_valid,
  input  logic [PRIO_W-1:0] ack_prio,
  input  logic              ack_grp,
  input  logic              drop_valid,
  input  logic              drop_grp,
  input  logic [ID_W-1:0]   drop_id,
  output logic [RUN_W-1:0]  run_prio,
  output logic [LEVELS-1:0] act_g0,
  output logic [LEVELS-1:0] act_g1
);
  logic [PRIO_W-1:0] gprio;
  logic [LVL_W-1:0]  ack_lvl;
  logic              id_ok;
  logic              drop_ok;
  logic [LEVELS-1:0] nx_g0;
  logic [LEVELS-1:0] nx_g1;
  logic [LVL_W-1:0]  low_idx;
  logic              low_any;
  logic [RUN_W-1:0]  rec_prio;
  logic [RUN_W-1:0]  run_nx;
  logic              run_en;

  apt_bpr #(.MIN_BP(MIN_BP)) u_bpr (
    .clk(clk), .rst_n(rst_n), .we(bp_we), .wdata(bp_wdata), .bp_q(bp_q)
  );

  apt_gprio #(.MIN_BP(MIN_BP)) u_gprio (
    .bp(bp_q), .prio(ack_prio), .gprio(gprio), .level(ack_lvl)
  );

  // A drop counts only for an implemented ID while something is running.
  assign id_ok   = ({22'd0, drop_id} < 32'(NUM_IRQ));
  assign drop_ok = drop_valid & id_ok & (run_prio != RUN_IDLE);

  apt_bank #(.LEVELS(LEVELS), .WORD_W(WORD_W)) u_bank_g0 (
    .clk(clk), .rst_n(rst_n),
    .set_en(ack_valid & ~ack_grp), .set_lvl(ack_lvl),
    .clr_en(drop_ok & ~drop_grp),
    .bits_q(act_g0), .bits_nx(nx_g0)
  );

  apt_bank #(.LEVELS(LEVELS), .WORD_W(WORD_W)) u_bank_g1 (
    .clk(clk), .rst_n(rst_n),
    .set_en(ack_valid & ack_grp), .set_lvl(ack_lvl),
    .clr_en(drop_ok & drop_grp),
    .bits_q(act_g1), .bits_nx(nx_g1)
  );

  apt_lowest #(.N(LEVELS)) u_lowest (
    .vec(nx_g0 | nx_g1), .idx(low_idx), .any(low_any)
  );

  assign rec_prio = low_any ? {1'b0, low_idx, {(MIN_BP+1){1'b0}}} : RUN_IDLE;

  // An acknowledge in the same cycle wins over the recomputed value.
  always_comb begin
    run_nx = run_prio;
    if (ack_valid)    run_nx = {1'b0, gprio};
    else if (drop_ok) run_nx = rec_prio;
  end
  assign run_en = ack_valid | drop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_prio <= RUN_IDLE;
    else if (run_en) run_prio <= run_nx;
  end
endmodule

// File: rtl/active_prio_tracker_chk.sv
module active_prio_tracker_chk #(
  parameter int MIN_BP  = 0,
  parameter int NUM_IRQ = 96,
  parameter int ID_W    = 10,
  parameter int LEVELS  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        bp_q,
  input logic              ack_valid,
  input logic              ack_grp,
  input logic              drop_valid,
  input logic              drop_grp,
  input logic [ID_W-1:0]   drop_id,
  input logic [8:0]        run_prio,
  input logic [LEVELS-1:0] act_g0,
  input logic [LEVELS-1:0] act_g1
);
  logic live;
  logic bad_id;

  assign live   = (run_prio != 9'h100);
  assign bad_id = ({22'd0, drop_id} >= 32'(NUM_IRQ));

  a_r8_bp_floor: assert property (@(posedge clk) disable iff (!rst_n)
    32'(bp_q) >= MIN_BP);

  a_r2_ack_marks_bank: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !ack_grp |=> act_g0 != '0);

  a_r3_ack_run_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> run_prio[8] == 1'b0);

  a_r4_drop_pops_one: assert property (@(posedge clk) disable iff (!rst_n)
    drop_valid && !bad_id && live && !ack_valid && !drop_grp && act_g0 != '0
    |=> ($countones(act_g0) == $countones($past(act_g0)) - 1)
        && ((act_g0 & ~$past(act_g0)) == '0) && $stable(act_g1));

  a_r5_idle_iff_empty: assert property (@(posedge clk) disable iff (!rst_n)
    drop_valid && !bad_id && live && !ack_valid
    |=> (((act_g0 | act_g1) == '0) == (run_prio == 9'h100)));

  a_r6_idle_drop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    drop_valid && !live && !ack_valid
    |=> $stable(act_g0) && $stable(act_g1) && run_prio == 9'h100);

  a_r7_bad_id_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    drop_valid && bad_id && !ack_valid
    |=> $stable(act_g0) && $stable(act_g1) && $stable(run_prio));
endmodule

bind active_prio_tracker active_prio_tracker_chk #(
  .MIN_BP(MIN_BP), .NUM_IRQ(NUM_IRQ), .ID_W(ID_W), .LEVELS(LEVELS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bp_q(bp_q), .ack_valid(ack_valid),
  .ack_grp(ack_grp), .drop_valid(drop_valid), .drop_grp(drop_grp),
  .drop_id(drop_id), .run_prio(run_prio), .act_g0(act_g0), .act_g1(act_g1)
);

// File: tb/active_prio_tracker_test.sv
module active_prio_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bp_we = 1'b0;
  logic [7:0]  bp_wdata = '0;
  logic        ack_valid = 1'b0;
  logic [7:0]  ack_prio = '0;
  logic        ack_grp = 1'b0;
  logic        drop_valid = 1'b0;
  logic        drop_grp = 1'b0;
  logic [9:0]  drop_id = '0;

  logic [2:0]   bp_q, b_bp_q;
  logic [8:0]   run_prio, b_run_prio;
  logic [127:0] act_g0, act_g1;
  logic [31:0]  b_act_g0, b_act_g1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  active_prio_tracker uut (
    .clk(clk), .rst_n(rst_n), .bp_we(bp_we), .bp_wdata(bp_wdata), .bp_q(bp_q),
    .ack_valid(ack_valid), .ack_prio(ack_prio), .ack_grp(ack_grp),
    .drop_valid(drop_valid), .drop_grp(drop_grp), .drop_id(drop_id),
    .run_prio(run_prio), .act_g0(act_g0), .act_g1(act_g1)
  );

  active_prio_tracker #(.MIN_BP(2), .NUM_IRQ(64)) uut_b (
    .clk(clk), .rst_n(rst_n), .bp_we(bp_we), .bp_wdata(bp_wdata), .bp_q(b_bp_q),
    .ack_valid(ack_valid), .ack_prio(ack_prio), .ack_grp(ack_grp),
    .drop_valid(drop_valid), .drop_grp(drop_grp), .drop_id(drop_id),
    .run_prio(b_run_prio), .act_g0(b_act_g0), .act_g1(b_act_g1)
  );

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] bit_at(int i);
    return 128'd1 << i;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bp_we = 1'b0; ack_valid = 1'b0; drop_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One event cycle: drive at a falling edge, outputs settled at the next.
  task automatic ev(bit a, logic [7:0] p, bit ag, bit d, bit dg, logic [9:0] id);
    @(negedge clk);
    ack_valid = a; ack_prio = p; ack_grp = ag;
    drop_valid = d; drop_grp = dg; drop_id = id;
    @(negedge clk);
    ack_valid = 1'b0; drop_valid = 1'b0;
  endtask

  task automatic set_bp(logic [7:0] v);
    @(negedge clk);
    bp_we = 1'b1; bp_wdata = v;
    @(negedge clk);
    bp_we = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 run_prio in reset", 128'(run_prio), 128'h100);
    do_reset();
    chk("R10 run_prio after reset", 128'(run_prio), 128'h100);
    chk("R10 g0 empty", act_g0, '0);
    chk("R10 g1 empty", act_g1, '0);
    chk("R10 bp at floor", 128'(bp_q), 128'd0);
    chk("R10 b bp at floor", 128'(b_bp_q), 128'd2);
  endtask

  task automatic t_mask();
    do_reset();
    set_bp(8'd3);
    ev(1, 8'h5A, 0, 0, 0, 0);
    chk("R1 R3 bp3 run", 128'(run_prio), 128'h050);
    chk("R2 bp3 level 40 in g0", act_g0, bit_at(40));
    chk("R2 g1 untouched", act_g1, '0);
    set_bp(8'd7);
    ev(1, 8'hFF, 1, 0, 0, 0);
    chk("R1 bp7 run zero", 128'(run_prio), 128'h000);
    chk("R2 bp7 level 0 in g1", act_g1, bit_at(0));
    set_bp(8'd0);
    ev(1, 8'h43, 0, 0, 0, 0);
    chk("R1 bp0 keeps 7:1", 128'(run_prio), 128'h042);
    chk("R2 bp0 level 33", act_g0, bit_at(40) | bit_at(33));
  endtask

  task automatic t_drop();
    do_reset();
    ev(1, 8'h80, 1, 0, 0, 0);
    ev(1, 8'h40, 0, 0, 0, 0);
    ev(1, 8'h20, 1, 0, 0, 0);
    chk("R3 nested run", 128'(run_prio), 128'h020);
    ev(0, 0, 0, 1, 1, 10'd5);
    chk("R4 g1 lowest popped", act_g1, bit_at(64));
    chk("R4 g0 kept", act_g0, bit_at(32));
    chk("R5 run from other bank", 128'(run_prio), 128'h040);
    ev(0, 0, 0, 1, 0, 10'd5);
    chk("R5 run across words", 128'(run_prio), 128'h080);
    ev(0, 0, 0, 1, 1, 10'd5);
    chk("R5 empty gives idle", 128'(run_prio), 128'h100);
    chk("R4 g1 empty", act_g1, '0);
    ev(1, 8'h10, 0, 0, 0, 0);
    ev(1, 8'h30, 1, 0, 0, 0);
    ev(0, 0, 0, 1, 0, 10'd7);
    chk("R4 bank chosen by group", act_g0, '0);
    chk("R4 other bank stays", act_g1, bit_at(24));
    chk("R5 rebuilt from g1", 128'(run_prio), 128'h030);
  endtask

  task automatic t_idle();
    do_reset();
    ev(0, 0, 0, 1, 0, 10'd1);
    chk("R6 idle drop run", 128'(run_prio), 128'h100);
    chk("R6 idle drop g0", act_g0, '0);
    chk("R6 idle drop g1", act_g1, '0);
  endtask

  task automatic t_badid();
    do_reset();
    ev(1, 8'h60, 0, 0, 0, 0);
    ev(0, 0, 0, 1, 0, 10'd1023);
    chk("R7 spurious run", 128'(run_prio), 128'h060);
    chk("R7 spurious bank", act_g0, bit_at(48));
    ev(0, 0, 0, 1, 0, 10'd96);
    chk("R7 id at limit run", 128'(run_prio), 128'h060);
    chk("R7 id at limit bank", act_g0, bit_at(48));
    ev(0, 0, 0, 1, 0, 10'd95);
    chk("R7 last valid id", 128'(run_prio), 128'h100);
  endtask

  task automatic t_same();
    do_reset();
    ev(1, 8'h40, 0, 0, 0, 0);
    ev(1, 8'h20, 0, 1, 0, 10'd3);
    chk("R9 drop then set", act_g0, bit_at(16));
    chk("R9 run from ack", 128'(run_prio), 128'h020);
    do_reset();
    ev(1, 8'h70, 1, 1, 1, 10'd3);
    chk("R9 idle drop skipped", act_g1, bit_at(56));
    chk("R9 idle run from ack", 128'(run_prio), 128'h070);
  endtask

  task automatic t_bp();
    do_reset();
    set_bp(8'd0);
    chk("R8 b clamp 0", 128'(b_bp_q), 128'd2);
    set_bp(8'd1);
    chk("R8 b clamp 1", 128'(b_bp_q), 128'd2);
    set_bp(8'd6);
    chk("R8 b keeps 6", 128'(b_bp_q), 128'd6);
    set_bp(8'hFD);
    chk("R8 low bits only", 128'(bp_q), 128'd5);
    chk("R8 b low bits only", 128'(b_bp_q), 128'd5);
    set_bp(8'd2);
    ev(1, 8'h5F, 0, 0, 0, 0);
    chk("R1 b run", 128'(b_run_prio), 128'h058);
    chk("R2 b level 11", 128'(b_act_g0), bit_at(11));
    ev(0, 0, 0, 1, 0, 10'd64);
    chk("R7 b id limit", 128'(b_run_prio), 128'h058);
    ev(0, 0, 0, 1, 0, 10'd63);
    chk("R5 b idle", 128'(b_run_prio), 128'h100);
  endtask

  initial begin
    t_reset();
    t_mask();
    t_drop();
    t_idle();
    t_badid();
    t_same();
    t_bp();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule